// File: doc/BRIEF.md
# Late-Write Buffer with Read Bypass

This block is the write path and read port of a pipelined synchronous memory model. A write command registers its address on one clock edge. Its data follows one cycle later, on one lane for a single-rate write or on two parallel lanes for a double-rate write. The captured address and data are parked in a two-stage holding register. They move into the storage array only when the data of the next write is captured. Until then, any read whose beat address equals a parked word is answered from the holding register instead of the array. The requester therefore always sees the most recent write.

Reads are registered on one edge and drive the output registers on the next edge. A double-rate read returns the addressed word on lane A and its partner word (address bit 0 inverted) on lane B. The outputs are quiet, meaning enable low and both lanes zero, in any cycle that does not follow a read. A turnaround guard flags a write that follows a read with fewer than two idle commands between them.

Two state machines shape the block. The parking machine has three states. WP_EMPTY: nothing has been captured. WP_CAPTURE: write data is expected in this cycle. WP_PARKED: a word is held. Its transitions are: a write takes any state to WP_CAPTURE; a non-write takes WP_CAPTURE to WP_PARKED; otherwise the state holds. The turnaround guard also has three states. TG_CLEAR: no recent read. TG_LAST: the previous command was a read. TG_GAP1: one idle has followed a read. Its transitions are: a read takes any state to TG_LAST; an idle takes TG_LAST to TG_GAP1 and TG_GAP1 to TG_CLEAR; a write takes any state to TG_CLEAR.

Top module: `late_write_buf`

## Requirements
- R1: `cmd_op` encodes the command as follows: 2'b00 is idle, 2'b01 is read, 2'b10 is write, and 2'b11 is treated exactly as idle. `cmd_ddr`=1 selects two beats.
- R2: Write data is taken from the lanes in the cycle after the write command. In a single-rate write, lane B is ignored and the partner word keeps its previous contents.
- R3: A double-rate write stores lane A at address A and lane B at the partner address, which is A with bit 0 inverted. A double-rate read returns word A on `q_lane_a`, the partner word on `q_lane_b`, and drives `q_ddr` high.
- R4: A read registered at edge k drives `q_oe` high with its data after edge k+1.
- R5: Every read beat returns the latest data written to that address. This includes a parked write not yet committed to the array, located by a full-address compare per beat.
- R6: A parked write is committed when the next write's data is captured. Data from earlier writes stays readable after later writes to other addresses.
- R7: After a non-read command, `q_oe` and `q_ddr` are low and both lanes read zero.
- R8: `turn_err` is high for one cycle after a write that follows the last read with zero or one idle command. After two or more idles it stays low. The write is performed in either case.
- R9: After reset, `q_oe`, `q_ddr`, `turn_err` and both lanes are low, and every array word reads as zero.
- R10: A single-rate read drives `q_ddr` low and `q_lane_b` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 2 | Command code (R1) |
| cmd_ddr | input | 1 | Double-rate select for the command |
| cmd_addr | input | AW | Word address of the command |
| wr_lane_a | input | DW | Write data, first beat (cycle after write) |
| wr_lane_b | input | DW | Write data, second beat (double-rate only) |
| q_oe | output | 1 | Read data valid / output drive enable |
| q_ddr | output | 1 | Current read has two beats |
| q_lane_a | output | DW | Read data, first beat |
| q_lane_b | output | DW | Read data, second beat |
| turn_err | output | 1 | Read-to-write turnaround violation |

## Verification
Several properties are checked on every cycle. The output enable may rise only after a registered read. The lanes must stay zero while the enable is low, and `q_ddr` is never high without the enable. Capture must follow a write command, and the parked-valid flag never drops. An error may appear only after a write, and a read followed directly by a write must raise the error. The bench scenarios check the data itself against an independent model of memory: bypass of uncommitted words on either lane, deferred commit across chains of writes, the ignored second lane of single-rate writes, and the exact idle count that separates a legal turnaround from an illegal one.

// File: rtl/lwb_pkg.sv
package lwb_pkg;
    typedef enum logic [1:0] {
        OP_NOP = 2'b00,
        OP_RD  = 2'b01,
        OP_WR  = 2'b10,
        OP_RSV = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        WP_EMPTY   = 2'd0,
        WP_CAPTURE = 2'd1,
        WP_PARKED  = 2'd2
    } wpark_e;

    typedef enum logic [1:0] {
        TG_CLEAR = 2'd0,
        TG_LAST  = 2'd1,
        TG_GAP1  = 2'd2
    } tguard_e;
endpackage

// File: rtl/lwb_write_park.sv
module lwb_write_park
    import lwb_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cmd,
    input  logic          cmd_ddr,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] wdata_a,
    input  logic [DW-1:0] wdata_b,
    output logic          pend_valid,
    output logic          pend_ddr,
    output logic [AW-1:0] pend_addr,
    output logic [DW-1:0] pend_a,
    output logic [DW-1:0] pend_b,
    output logic          commit_en
);
    wpark_e        st_q, st_d;
    logic          cap_ddr;
    logic [AW-1:0] cap_addr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= WP_EMPTY;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WP_EMPTY:   if (wr_cmd) st_d = WP_CAPTURE;
            WP_CAPTURE: st_d = wr_cmd ? WP_CAPTURE : WP_PARKED;
            WP_PARKED:  if (wr_cmd) st_d = WP_CAPTURE;
            default:    st_d = WP_EMPTY;
        endcase
    end

    // outputs: commit the old parked word as the new data lands
    always_comb begin
        commit_en = 1'b0;
        unique case (st_q)
            WP_CAPTURE: commit_en = pend_valid;
            default:    commit_en = 1'b0;
        endcase
    end

    // stage one: address of the latest write command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_ddr  <= 1'b0;
        end else if (wr_cmd) begin
            cap_addr <= cmd_addr;
            cap_ddr  <= cmd_ddr;
        end
    end

    // stage two: parked word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_ddr   <= 1'b0;
            pend_addr  <= '0;
            pend_a     <= '0;
            pend_b     <= '0;
        end else if (st_q == WP_CAPTURE) begin
            pend_valid <= 1'b1;
            pend_ddr   <= cap_ddr;
            pend_addr  <= cap_addr;
            pend_a     <= wdata_a;
            pend_b     <= cap_ddr ? wdata_b : '0;
        end
    end

    // R2
    capture_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WP_CAPTURE) |-> $past(wr_cmd));

    // R6
    park_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |=> pend_valid);
endmodule

// File: rtl/lwb_turn_guard.sv
module lwb_turn_guard
    import lwb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic is_rd,
    input  logic is_wr,
    output logic turn_err
);
    tguard_e st_q, st_d;
    logic    viol;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TG_CLEAR;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        viol = 1'b0;
        unique case (st_q)
            TG_CLEAR: begin
                if (is_rd) st_d = TG_LAST;
            end
            TG_LAST: begin
                if (is_rd)      st_d = TG_LAST;
                else if (is_wr) begin st_d = TG_CLEAR; viol = 1'b1; end
                else            st_d = TG_GAP1;
            end
            TG_GAP1: begin
                if (is_rd)      st_d = TG_LAST;
                else if (is_wr) begin st_d = TG_CLEAR; viol = 1'b1; end
                else            st_d = TG_CLEAR;
            end
            default: st_d = TG_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) turn_err <= 1'b0;
        else        turn_err <= viol;
    end

    // R8
    err_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        turn_err |-> $past(is_wr));

    // R8
    back_to_back_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd ##1 is_wr |=> turn_err);
endmodule

// File: rtl/lwb_array_port.sv
module lwb_array_port #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_cmd,
    input  logic          cmd_ddr,
    input  logic [AW-1:0] cmd_addr,
    input  logic          commit_en,
    input  logic          pend_valid,
    input  logic          pend_ddr,
    input  logic [AW-1:0] pend_addr,
    input  logic [DW-1:0] pend_a,
    input  logic [DW-1:0] pend_b,
    output logic          q_oe,
    output logic          q_ddr,
    output logic [DW-1:0] q_lane_a,
    output logic [DW-1:0] q_lane_b
);
    localparam int DEPTH = 1 << AW;
    localparam int BEATS = 2;

    function automatic logic [AW-1:0] partner(input logic [AW-1:0] a);
        return {a[AW-1:1], ~a[0]};
    endfunction

    logic [DW-1:0] mem [DEPTH];
    logic          rq_valid, rq_ddr;
    logic [AW-1:0] rq_addr;
    logic [AW-1:0] beat_addr [BEATS];
    logic [DW-1:0] beat_word [BEATS];

    // array, written only on commit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (commit_en) begin
            mem[pend_addr] <= pend_a;
            if (pend_ddr) mem[partner(pend_addr)] <= pend_b;
        end
    end

    // read command stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq_valid <= 1'b0;
            rq_ddr   <= 1'b0;
            rq_addr  <= '0;
        end else begin
            rq_valid <= rd_cmd;
            if (rd_cmd) begin
                rq_ddr  <= cmd_ddr;
                rq_addr <= cmd_addr;
            end
        end
    end

    assign beat_addr[0] = rq_addr;
    assign beat_addr[1] = partner(rq_addr);

    // per-beat bypass against the parked word
    for (genvar b = 0; b < BEATS; b++) begin : g_beat
        logic hit_a, hit_b;
        always_comb begin
            hit_a = pend_valid && (beat_addr[b] == pend_addr);
            hit_b = pend_valid && pend_ddr && (beat_addr[b] == partner(pend_addr));
            if (hit_a)      beat_word[b] = pend_a;
            else if (hit_b) beat_word[b] = pend_b;
            else            beat_word[b] = mem[beat_addr[b]];
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_oe     <= 1'b0;
            q_ddr    <= 1'b0;
            q_lane_a <= '0;
            q_lane_b <= '0;
        end else if (rq_valid) begin
            q_oe     <= 1'b1;
            q_ddr    <= rq_ddr;
            q_lane_a <= beat_word[0];
            q_lane_b <= rq_ddr ? beat_word[1] : '0;
        end else begin
            q_oe     <= 1'b0;
            q_ddr    <= 1'b0;
            q_lane_a <= '0;
            q_lane_b <= '0;
        end
    end

    // R4
    oe_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_oe |-> $past(rd_cmd, 2));

    // R7
    quiet_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q_oe |-> (q_lane_a == '0 && q_lane_b == '0));

    // R10
    ddr_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_ddr |-> q_oe);

    // R10
    single_b_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_oe && !q_ddr) |-> (q_lane_b == '0));
endmodule

// File: rtl/late_write_buf.sv
module late_write_buf
    import lwb_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cmd_op,
    input  logic          cmd_ddr,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] wr_lane_a,
    input  logic [DW-1:0] wr_lane_b,
    output logic          q_oe,
    output logic          q_ddr,
    output logic [DW-1:0] q_lane_a,
    output logic [DW-1:0] q_lane_b,
    output logic          turn_err
);
    logic          is_rd, is_wr;
    logic          pend_valid, pend_ddr, commit_en;
    logic [AW-1:0] pend_addr;
    logic [DW-1:0] pend_a, pend_b;

    // R1
    assign is_rd = (cmd_op == OP_RD);
    assign is_wr = (cmd_op == OP_WR);

    lwb_write_park #(.AW(AW), .DW(DW)) u_park (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_cmd     (is_wr),
        .cmd_ddr    (cmd_ddr),
        .cmd_addr   (cmd_addr),
        .wdata_a    (wr_lane_a),
        .wdata_b    (wr_lane_b),
        .pend_valid (pend_valid),
        .pend_ddr   (pend_ddr),
        .pend_addr  (pend_addr),
        .pend_a     (pend_a),
        .pend_b     (pend_b),
        .commit_en  (commit_en)
    );

    lwb_array_port #(.AW(AW), .DW(DW)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_cmd     (is_rd),
        .cmd_ddr    (cmd_ddr),
        .cmd_addr   (cmd_addr),
        .commit_en  (commit_en),
        .pend_valid (pend_valid),
        .pend_ddr   (pend_ddr),
        .pend_addr  (pend_addr),
        .pend_a     (pend_a),
        .pend_b     (pend_b),
        .q_oe       (q_oe),
        .q_ddr      (q_ddr),
        .q_lane_a   (q_lane_a),
        .q_lane_b   (q_lane_b)
    );

    lwb_turn_guard u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .is_rd    (is_rd),
        .is_wr    (is_wr),
        .turn_err (turn_err)
    );
endmodule

// File: tb/late_write_buf_bench.sv
`timescale 1ns/1ps
module late_write_buf_bench;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    cmd_op;
    logic          cmd_ddr;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] wr_lane_a, wr_lane_b;
    logic          q_oe, q_ddr, turn_err;
    logic [DW-1:0] q_lane_a, q_lane_b;

    always #10 clk = ~clk;

    late_write_buf #(.AW(AW), .DW(DW)) u_late_write_buf (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_ddr(cmd_ddr),
        .cmd_addr(cmd_addr), .wr_lane_a(wr_lane_a), .wr_lane_b(wr_lane_b),
        .q_oe(q_oe), .q_ddr(q_ddr), .q_lane_a(q_lane_a), .q_lane_b(q_lane_b),
        .turn_err(turn_err)
    );

    int errs = 0;
    int checks = 0;
    bit done = 0;

    logic [DW-1:0] model [N];

    // expectation pipeline: p1 = last step, p2 = two steps ago
    logic          p1_oe = 0, p1_ddr = 0, p2_oe = 0, p2_ddr = 0;
    logic [DW-1:0] p1_a = 0, p1_b = 0, p2_a = 0, p2_b = 0;
    string         p1_tag = "R7", p2_tag = "R7";
    logic          perr = 0;
    logic [1:0]    prev1 = 2'b00, prev2 = 2'b00;
    logic          wp = 0, wp_ddr = 0;
    logic [AW-1:0] wp_addr = 0;
    logic [DW-1:0] wp_a = 0, wp_b = 0;

    function automatic logic [AW-1:0] mate(input logic [AW-1:0] a);
        return {a[AW-1:1], ~a[0]};
    endfunction

    function automatic logic exp_err(input logic [1:0] op, input logic [1:0] pr1,
                                     input logic [1:0] pr2);
        logic idle1;
        idle1 = (pr1 != 2'b01) && (pr1 != 2'b10);
        return (op == 2'b10) && ((pr1 == 2'b01) || (idle1 && pr2 == 2'b01));
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] op, input logic ddr, input logic [AW-1:0] addr,
                        input logic [DW-1:0] wa, input logic [DW-1:0] wb, input string tag);
        // outputs for the command of two steps ago
        chk(p2_oe ? "R4" : p2_tag, "q_oe", {31'd0, q_oe}, {31'd0, p2_oe});
        chk(p2_tag, "q_ddr", {31'd0, q_ddr}, {31'd0, p2_ddr});
        chk(p2_tag, "q_lane_a", {16'd0, q_lane_a}, {16'd0, p2_a});
        chk(p2_tag, "q_lane_b", {16'd0, q_lane_b}, {16'd0, p2_b});
        // R8: error flag for the previous command
        chk("R8", "turn_err", {31'd0, turn_err}, {31'd0, perr});
        // data beat(s) for the previous write
        if (wp) begin
            wr_lane_a = wp_a;
            wr_lane_b = wp_b;
            model[wp_addr] = wp_a;
            if (wp_ddr) model[mate(wp_addr)] = wp_b;
        end else begin
            wr_lane_a = DW'($urandom);
            wr_lane_b = DW'($urandom);
        end
        // shift pipeline, build expectation for this command
        p2_oe = p1_oe; p2_ddr = p1_ddr; p2_a = p1_a; p2_b = p1_b; p2_tag = p1_tag;
        if (op == 2'b01) begin
            p1_oe  = 1'b1;
            p1_ddr = ddr;
            p1_a   = model[addr];
            p1_b   = ddr ? model[mate(addr)] : '0;
        end else begin
            p1_oe = 1'b0; p1_ddr = 1'b0; p1_a = '0; p1_b = '0;
        end
        p1_tag = tag;
        perr   = exp_err(op, prev1, prev2);
        prev2  = prev1;
        prev1  = op;
        wp      = (op == 2'b10);
        wp_ddr  = ddr;
        wp_addr = addr;
        wp_a    = wa;
        wp_b    = wb;
        cmd_op   = op;
        cmd_ddr  = ddr;
        cmd_addr = addr;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(2'b00, 1'b0, '0, '0, '0, "R7");
    endtask

    initial begin
        #(20.0 * 150000);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < N; i++) model[i] = '0;
        rst_n = 1'b0; cmd_op = 2'b00; cmd_ddr = 1'b0; cmd_addr = '0;
        wr_lane_a = '0; wr_lane_b = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk("R9", "q_oe", {31'd0, q_oe}, 32'd0);
        chk("R9", "q_ddr", {31'd0, q_ddr}, 32'd0);
        chk("R9", "turn_err", {31'd0, turn_err}, 32'd0);
        chk("R9", "q_lane_a", {16'd0, q_lane_a}, 32'd0);

        // R9: unwritten word reads zero (double-rate read, R3 lane layout)
        step(2'b01, 1'b1, 6'd5, '0, '0, "R9");
        idle(2);
        // R2: single-rate write ignores lane B; R5 bypass of parked word
        step(2'b10, 1'b0, 6'd4, 16'h1111, 16'h2222, "R2");
        step(2'b01, 1'b1, 6'd4, '0, '0, "R2");
        idle(2);
        // R3 + R5: double-rate write, partner read from parked lane B
        step(2'b10, 1'b1, 6'd9, 16'hAAAA, 16'hBBBB, "R3");
        step(2'b01, 1'b0, 6'd8, '0, '0, "R5");
        step(2'b01, 1'b1, 6'd8, '0, '0, "R3");
        step(2'b01, 1'b0, 6'd9, '0, '0, "R10");
        idle(2);
        // R6: chain of writes then reads of the older ones
        step(2'b10, 1'b1, 6'd20, 16'h2020, 16'h2121, "R6");
        step(2'b10, 1'b0, 6'd30, 16'h3030, 16'h0000, "R6");
        step(2'b10, 1'b0, 6'd40, 16'h4040, 16'h0000, "R6");
        step(2'b01, 1'b1, 6'd21, '0, '0, "R6");
        step(2'b01, 1'b0, 6'd30, '0, '0, "R6");
        step(2'b01, 1'b0, 6'd40, '0, '0, "R6");
        idle(2);
        // R8: zero idles, one idle, two idles
        step(2'b01, 1'b0, 6'd1, '0, '0, "R10");
        step(2'b10, 1'b0, 6'd50, 16'h5050, '0, "R8");
        step(2'b01, 1'b0, 6'd50, '0, '0, "R8");
        idle(1);
        step(2'b10, 1'b0, 6'd51, 16'h5151, '0, "R8");
        step(2'b01, 1'b0, 6'd51, '0, '0, "R8");
        idle(2);
        step(2'b10, 1'b0, 6'd52, 16'h5252, '0, "R8");
        step(2'b01, 1'b0, 6'd52, '0, '0, "R8");
        // R1: code 11 acts as idle (no output, counts toward the gap)
        step(2'b11, 1'b1, 6'd52, '0, '0, "R1");
        step(2'b11, 1'b0, 6'd0, '0, '0, "R1");
        step(2'b10, 1'b1, 6'd60, 16'h6060, 16'h6161, "R1");
        step(2'b01, 1'b1, 6'd60, '0, '0, "R1");
        idle(3);

        // random phase, small address window to force bypass hits
        for (int i = 0; i < 2000; i++) begin
            int r;
            logic [1:0] op;
            r = int'($urandom % 10);
            op = (r < 4) ? 2'b01 : (r < 7) ? 2'b10 : (r < 9) ? 2'b00 : 2'b11;
            step(op, 1'($urandom), AW'($urandom % 16), DW'($urandom), DW'($urandom),
                 op == 2'b01 ? "R5" : "R7");
        end
        idle(3);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule